// File: doc/BRIEF.md
# Configurable register logic cell

This cell sits behind a programmable OR plane and turns a group of four sum-of-products terms into two outputs. It holds one storage bit whose behaviour is chosen by configuration: a D, T or JK flip-flop. Unlike a cell with dedicated clock and reset pins, its clock and its asynchronous set or clear are each taken from one of the four sum terms. The logic that produces those terms is therefore responsible for keeping them free of glitches.

Each term has a fixed role. Term 0 is the data, toggle or J input. Term 1 is the K input in JK mode, and in D and T modes it is the combinational value offered to the outputs. Term 2 is the flip-flop clock, active on its rising edge. Term 3 is routed either to an asynchronous clear or to an asynchronous preset, as chosen by a configuration bit; whichever of the two is not selected stays inactive. A global reset input clears the bit regardless of the terms and wins over a preset.

Two independent selectors each pick the registered bit or the combinational value. One drives the pin path, together with a plain output-enable for the pad. The other is buried and only feeds back into the logic planes. Configuration inputs are static levels, and no valid/ready flow control applies: every term is a level that is consumed whenever it is present.

Top module: `cfg_reg_cell`

## Requirements
- R1: While glob_rst_i is 1 the stored bit is 0 at once, without any term clock edge, and rising edges of term 2 leave it at 0.
- R2: With ff_mode_i = 2'b00 (D), and also with the spare code 2'b11, a rising edge of term 2 stores term 0.
- R3: With ff_mode_i = 2'b01 (T), a rising edge of term 2 inverts the stored bit when term 0 is 1 and keeps it when term 0 is 0.
- R4: With ff_mode_i = 2'b10 (JK), on a rising edge of term 2, with J = term 0 and K = term 1: J=0,K=0 holds; J=1,K=0 sets; J=0,K=1 clears; J=1,K=1 inverts.
- R5: With t3_clr_sel_i = 1, term 3 at 1 clears the stored bit asynchronously and keeps it cleared across term clock edges; it never sets the bit.
- R6: With t3_clr_sel_i = 0, term 3 at 1 sets the stored bit asynchronously and keeps it set across term clock edges; it never clears the bit.
- R7: Global reset takes priority over a preset from term 3: with both active the stored bit is 0.
- R8: The combinational value is term 1 in D and T modes (codes 2'b00, 2'b01, 2'b11) and term 0 in JK mode (2'b10).
- R9: pin_o carries the stored bit when pin_reg_sel_i is 1 and the combinational value when it is 0.
- R10: fb_o carries the stored bit when fb_reg_sel_i is 1 and the combinational value when it is 0, independently of the pin selector.
- R11: pin_oe_o follows pin_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glob_rst_i | input | 1 | Global asynchronous clear of the stored bit, active high |
| sum_i | input | 4 | Sum terms: 0 data/T/J, 1 K or combinational value, 2 clock, 3 preset or clear |
| ff_mode_i | input | 2 | Storage type: 00 D, 01 T, 10 JK, 11 treated as D |
| t3_clr_sel_i | input | 1 | 1: term 3 is a clear; 0: term 3 is a preset |
| pin_reg_sel_i | input | 1 | Pin path source: 1 stored bit, 0 combinational value |
| fb_reg_sel_i | input | 1 | Buried path source: 1 stored bit, 0 combinational value |
| pin_en_i | input | 1 | Pad output enable request |
| pin_o | output | 1 | Pin path output |
| pin_oe_o | output | 1 | Pad output enable |
| fb_o | output | 1 | Buried feedback output |

## Verification
The combinational value, both selectors and the output enable respond with no register in the path, so their checks sample half a bench clock after the inputs move. A stored-bit result is due on the rising edge of term 2: the bench sets terms 0 and 1 on one falling bench-clock edge, raises term 2 on the next falling edge and samples on the following rising edge, one half period after the update. Term 3 and the global reset act without any clock, so their effects are sampled half a period after the level changes, and the bench only moves them while term 2 is low.

// File: rtl/cfg_reg_cell_pkg.sv
package cfg_reg_cell_pkg;

  localparam int unsigned NUM_TERMS = 4;
  localparam int unsigned MODE_W    = 2;

  localparam int unsigned TERM_DATA  = 0;
  localparam int unsigned TERM_AUX   = 1;
  localparam int unsigned TERM_CLK   = 2;
  localparam int unsigned TERM_ASYNC = 3;

  localparam int unsigned NUM_OUTS = 2;
  localparam int unsigned OUT_PIN  = 0;
  localparam int unsigned OUT_FB   = 1;

  typedef enum logic [MODE_W-1:0] {
    FF_D     = 2'b00,
    FF_T     = 2'b01,
    FF_JK    = 2'b10,
    FF_SPARE = 2'b11
  } ff_mode_e;

  typedef struct packed {
    logic din;
    logic aux;
    logic clk;
    logic set_a;
    logic clr_a;
    logic comb;
  } roles_t;

endpackage

// File: rtl/cfg_reg_role_map.sv
module cfg_reg_role_map
  import cfg_reg_cell_pkg::*;
(
  input  logic                 glob_rst_i,
  input  logic [NUM_TERMS-1:0] sum_i,
  input  ff_mode_e             mode_i,
  input  logic                 t3_clr_sel_i,
  output roles_t               roles_o
);

  logic async_term;
  assign async_term = sum_i[TERM_ASYNC];

  always_comb begin
    roles_o.din   = sum_i[TERM_DATA];
    roles_o.aux   = sum_i[TERM_AUX];
    roles_o.clk   = sum_i[TERM_CLK];
    roles_o.clr_a = glob_rst_i | (async_term & t3_clr_sel_i);
    roles_o.set_a = async_term & ~t3_clr_sel_i & ~glob_rst_i;
    roles_o.comb  = (mode_i == FF_JK) ? sum_i[TERM_DATA] : sum_i[TERM_AUX];
  end

  always_comb begin
    assert (!(roles_o.set_a && roles_o.clr_a))
      else $error("AST_SET_CLR_EXCLUSIVE"); // R7
  end

endmodule

// File: rtl/cfg_reg_next_state.sv
module cfg_reg_next_state
  import cfg_reg_cell_pkg::*;
(
  input  ff_mode_e mode_i,
  input  logic     q_i,
  input  logic     din_i,
  input  logic     aux_i,
  output logic     nxt_o
);

  always_comb begin
    unique case (mode_i)
      FF_T:  nxt_o = q_i ^ din_i;
      FF_JK: begin
        unique case ({din_i, aux_i})
          2'b00:   nxt_o = q_i;
          2'b10:   nxt_o = 1'b1;
          2'b01:   nxt_o = 1'b0;
          default: nxt_o = ~q_i;
        endcase
      end
      default: nxt_o = din_i;
    endcase
  end

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store (
  input  logic tclk_i,
  input  logic set_a_i,
  input  logic clr_a_i,
  input  logic nxt_i,
  output logic q_o
);

  always_ff @(posedge tclk_i or posedge clr_a_i or posedge set_a_i) begin
    if (clr_a_i)      q_o <= 1'b0;
    else if (set_a_i) q_o <= 1'b1;
    else              q_o <= nxt_i;
  end

  AST_CLEAR_HOLDS: assert property (@(posedge tclk_i) disable iff (set_a_i)
    clr_a_i |-> (q_o == 1'b0)) else $error("AST_CLEAR_HOLDS"); // R5

  AST_PRESET_HOLDS: assert property (@(posedge tclk_i) disable iff (clr_a_i)
    set_a_i |-> (q_o == 1'b1)) else $error("AST_PRESET_HOLDS"); // R6

endmodule

// File: rtl/cfg_reg_out_mux.sv
module cfg_reg_out_mux (
  input  logic sel_reg_i,
  input  logic q_i,
  input  logic comb_i,
  output logic out_o
);

  assign out_o = sel_reg_i ? q_i : comb_i;

endmodule

// File: rtl/cfg_reg_cell.sv
module cfg_reg_cell
  import cfg_reg_cell_pkg::*;
(
  input  logic                 glob_rst_i,
  input  logic [NUM_TERMS-1:0] sum_i,
  input  logic [MODE_W-1:0]    ff_mode_i,
  input  logic                 t3_clr_sel_i,
  input  logic                 pin_reg_sel_i,
  input  logic                 fb_reg_sel_i,
  input  logic                 pin_en_i,
  output logic                 pin_o,
  output logic                 pin_oe_o,
  output logic                 fb_o
);

  ff_mode_e mode;
  roles_t   roles;
  logic     q;
  logic     nxt;
  logic     tclk;
  logic     async_any;
  logic [NUM_OUTS-1:0] out_sel;
  logic [NUM_OUTS-1:0] out_val;

  assign mode = ff_mode_e'(ff_mode_i);

  cfg_reg_role_map u_roles (
    .glob_rst_i   (glob_rst_i),
    .sum_i        (sum_i),
    .mode_i       (mode),
    .t3_clr_sel_i (t3_clr_sel_i),
    .roles_o      (roles)
  );

  cfg_reg_next_state u_next (
    .mode_i (mode),
    .q_i    (q),
    .din_i  (roles.din),
    .aux_i  (roles.aux),
    .nxt_o  (nxt)
  );

  assign tclk = roles.clk;

  cfg_reg_store u_store (
    .tclk_i  (tclk),
    .set_a_i (roles.set_a),
    .clr_a_i (roles.clr_a),
    .nxt_i   (nxt),
    .q_o     (q)
  );

  assign out_sel[OUT_PIN] = pin_reg_sel_i;
  assign out_sel[OUT_FB]  = fb_reg_sel_i;

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_out
    cfg_reg_out_mux u_mux (
      .sel_reg_i (out_sel[g]),
      .q_i       (q),
      .comb_i    (roles.comb),
      .out_o     (out_val[g])
    );
  end

  assign pin_o    = out_val[OUT_PIN];
  assign fb_o     = out_val[OUT_FB];
  assign pin_oe_o = pin_en_i;

  assign async_any = glob_rst_i | sum_i[TERM_ASYNC];

  AST_D_LOADS: assert property (@(posedge tclk) disable iff (async_any)
    (mode == FF_D || mode == FF_SPARE) |=> (q == $past(sum_i[TERM_DATA])))
    else $error("AST_D_LOADS"); // R2

  AST_T_TOGGLES: assert property (@(posedge tclk) disable iff (async_any)
    (mode == FF_T && sum_i[TERM_DATA]) |=> (q != $past(q)))
    else $error("AST_T_TOGGLES"); // R3

  AST_JK_HOLDS: assert property (@(posedge tclk) disable iff (async_any)
    (mode == FF_JK && !sum_i[TERM_DATA] && !sum_i[TERM_AUX]) |=> $stable(q))
    else $error("AST_JK_HOLDS"); // R4

  AST_RESET_CLEARS: assert property (@(posedge tclk) disable iff (1'b0)
    glob_rst_i |-> (q == 1'b0)) else $error("AST_RESET_CLEARS"); // R1

endmodule

// File: tb/tb_cfg_reg_cell.sv
`timescale 1ns/1ps
module tb_cfg_reg_cell;

  logic       clk = 1'b0;
  logic       glob_rst;
  logic [3:0] sum;
  logic [1:0] mode;
  logic       t3_clr_sel, pin_reg_sel, fb_reg_sel, pin_en;
  logic       pin, pin_oe, fb;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #10 clk = ~clk;

  cfg_reg_cell dut (
    .glob_rst_i    (glob_rst),
    .sum_i         (sum),
    .ff_mode_i     (mode),
    .t3_clr_sel_i  (t3_clr_sel),
    .pin_reg_sel_i (pin_reg_sel),
    .fb_reg_sel_i  (fb_reg_sel),
    .pin_en_i      (pin_en),
    .pin_o         (pin),
    .pin_oe_o      (pin_oe),
    .fb_o          (fb)
  );

  // {mode[1:0], term0, term1, expected stored bit}
  localparam int NV = 12;
  localparam logic [4:0] VEC [NV] = '{
    5'b00_1_0_1, 5'b00_0_1_0, 5'b01_1_1_1, 5'b01_0_0_1,
    5'b01_1_0_0, 5'b10_1_0_1, 5'b10_0_0_1, 5'b10_0_1_0,
    5'b10_1_1_1, 5'b10_1_1_0, 5'b11_1_0_1, 5'b00_0_1_0
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // term clock rises at a falling bench edge; sample at the next rising edge
  task automatic tick();
    @(negedge clk) sum[2] = 1'b1;
    @(posedge clk);
  endtask

  task automatic untick();
    @(negedge clk) sum[2] = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    glob_rst = 1'b1; sum = 4'b0000; mode = 2'b00;
    t3_clr_sel = 1'b1; pin_reg_sel = 1'b0; fb_reg_sel = 1'b1; pin_en = 1'b0;
    @(posedge clk);
    check("R1 reset state", fb, 1'b0);
    check("R11 oe low", pin_oe, 1'b0);
    // R1: clock edges ignored while global reset is high
    @(negedge clk) sum[0] = 1'b1;
    tick();
    check("R1 clock ignored in reset", fb, 1'b0);
    untick();
    @(negedge clk) glob_rst = 1'b0;

    // table walk: fb shows stored bit, pin shows combinational value
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode   = VEC[i][4:3];
      sum[0] = VEC[i][2];
      sum[1] = VEC[i][1];
      tick();
      check("R2/R3/R4 stored bit", fb, VEC[i][0]);
      check("R8 comb value", pin, (VEC[i][4:3] == 2'b10) ? VEC[i][2] : VEC[i][1]);
      untick();
    end

    // R9 / R10: selectors
    @(negedge clk) begin mode = 2'b00; sum[0] = 1'b1; sum[1] = 1'b0;
      pin_reg_sel = 1'b1; fb_reg_sel = 1'b0; end
    tick();
    check("R9 pin shows stored bit", pin, 1'b1);
    check("R10 fb shows comb value", fb, 1'b0);
    untick();
    @(negedge clk) sum[1] = 1'b1;
    @(posedge clk);
    check("R10 fb follows comb", fb, 1'b1);
    check("R9 pin stays stored", pin, 1'b1);

    // R5: term 3 as clear
    @(negedge clk) begin fb_reg_sel = 1'b1; t3_clr_sel = 1'b1; sum[3] = 1'b1; end
    @(posedge clk);
    check("R5 async clear", fb, 1'b0);
    tick();
    check("R5 clear held over clock", fb, 1'b0);
    untick();
    @(negedge clk) sum[3] = 1'b0;
    @(posedge clk);
    check("R5 no set on release", fb, 1'b0);

    // R6: term 3 as preset
    @(negedge clk) begin t3_clr_sel = 1'b0; sum[0] = 1'b0; sum[3] = 1'b1; end
    @(posedge clk);
    check("R6 async preset", fb, 1'b1);
    tick();
    check("R6 preset held over clock", fb, 1'b1);
    untick();
    @(negedge clk) sum[3] = 1'b0;
    @(posedge clk);
    check("R6 no clear on release", fb, 1'b1);

    // R7: global reset beats preset
    @(negedge clk) sum[3] = 1'b1;
    @(negedge clk) glob_rst = 1'b1;
    @(posedge clk);
    check("R7 reset over preset", fb, 1'b0);
    @(negedge clk) sum[3] = 1'b0;
    @(negedge clk) glob_rst = 1'b0;
    @(posedge clk);
    check("R7 stays cleared", fb, 1'b0);

    // R11
    @(negedge clk) pin_en = 1'b1;
    @(posedge clk);
    check("R11 oe high", pin_oe, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule